// File: doc/BRIEF.md
# Edge-Selectable Sticky Event Status Register

This block holds one channel's worth of latched event flags for a line-interface alarm monitor. Five live status levels come in: a system-side alarm, a line-side alarm, a pattern-lock indication, an activate-code detector and a deactivate-code detector. Each live level is sampled once per clock. A qualifying change on a level sets its flag in an eight-bit status word, and the flag stays set until software clears it.

Three control inputs pick what counts as a qualifying change. Both alarm flags share one control, the two code flags share another, and the pattern-lock flag has its own. With the control low, only a low-to-high change sets the flag. With the control high, a change in either direction sets it. Software reads the status word directly and clears flags by writing ones. A registered, active-high interrupt output is raised while any flag is set.

Top module: `evt_sticky_status`

## Requirements
- R1: After reset, the status word reads 0x00 and the interrupt output is low.
- R2: With its edge control low, a 0-to-1 change on a live input sets that input's flag on the first clock edge that samples the new level. The flags sit at these bit positions: system alarm at bit 7, line alarm at bit 6, pattern lock at bit 5, activate code at bit 1, deactivate code at bit 0.
- R3: With its edge control low, a 1-to-0 change on a live input does not set its flag.
- R4: With its edge control high, a change in either direction sets the flag.
- R5: `alarm_anyedge_i` is the edge control for both bit 7 and bit 6.
- R6: `code_anyedge_i` is the edge control for both bit 1 and bit 0. `sync_anyedge_i` is the edge control for bit 5 only.
- R7: A write (`wr_en_i` high for one cycle) clears every flag whose `wr_data_i` bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: If a qualifying change and a clearing write reach the same flag on the same edge, the flag ends up set.
- R9: Bits 4 to 2 always read 0. Writes to those bits have no effect on any flag.
- R10: `irq_o` is the OR of the flags as registered on the previous edge, so it follows the status word one cycle later.
- R11: A flag stays set after its live input returns to its earlier level, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_alarm_i | input | 1 | Live system-side alarm level |
| line_alarm_i | input | 1 | Live line-side alarm level |
| pat_sync_i | input | 1 | Live pattern-lock level |
| act_code_i | input | 1 | Live activate-code detect level |
| deact_code_i | input | 1 | Live deactivate-code detect level |
| alarm_anyedge_i | input | 1 | Edge control for both alarm flags: 0 rising only, 1 any change |
| sync_anyedge_i | input | 1 | Edge control for the pattern-lock flag |
| code_anyedge_i | input | 1 | Edge control for both code flags |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | REG_W | Write data; a 1 clears the matching flag |
| rd_data_o | output | REG_W | Current status word |
| irq_o | output | 1 | Registered interrupt, high while any flag is set |

## Verification
The checker works out edges on its own from the value each input had on the previous clock. It therefore assumes that every live input is held low while reset is asserted, so that its history agrees with the block's previous-sample register, which is cleared in reset. It also assumes that inputs change only between clock edges. The bench drives every input on the falling edge and holds all live levels at 0 through each reset. The edge-control inputs are changed only while the live levels are stable.

// File: rtl/evt_status_pkg.sv
// Package: shared constants and helpers for the sticky event status block.
// Assumes an eight-bit status word with a layout fixed by software decode.
package evt_status_pkg;

    localparam int unsigned STAT_W  = 8;
    localparam int unsigned EVT_NUM = 5;

    // Event index (position in the live vector)
    typedef enum logic [2:0] {
        EVT_SYS_ALARM  = 3'd0,
        EVT_LINE_ALARM = 3'd1,
        EVT_PAT_SYNC   = 3'd2,
        EVT_ACT_CODE   = 3'd3,
        EVT_DEACT_CODE = 3'd4
    } evt_idx_e;

    // Edge-control groups
    typedef enum logic [1:0] {
        GRP_ALARM = 2'd0,
        GRP_SYNC  = 2'd1,
        GRP_CODE  = 2'd2
    } evt_grp_e;

    localparam int unsigned GRP_NUM = 3;

    // Bit mask of the implemented (non-reserved) status bits
    localparam logic [STAT_W-1:0] IMPL_MASK = 8'b1110_0011;

    // Status bit position of an event; software decodes this layout
    function automatic int unsigned evt_bit_pos(input int unsigned idx);
        case (idx)
            0:       return 7;
            1:       return 6;
            2:       return 5;
            3:       return 1;
            default: return 0;
        endcase
    endfunction

    // Edge-control group that governs an event
    function automatic int unsigned evt_group(input int unsigned idx);
        case (idx)
            0, 1:    return GRP_ALARM;
            2:       return GRP_SYNC;
            default: return GRP_CODE;
        endcase
    endfunction

endpackage

// File: rtl/evt_edge_qual.sv
// Edge qualifier: samples each live level once per clock and flags a
// qualifying change. Per event, mode 0 qualifies only 0->1 and mode 1
// qualifies any change. Assumes the live levels are already synchronous.
module evt_edge_qual #(
    parameter int unsigned N_EVT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] live_i,
    input  logic [N_EVT-1:0] any_mode_i,
    output logic [N_EVT-1:0] hit_o
);

    logic [N_EVT-1:0] prev_q;

    // Keep the previous sample of every live level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= live_i;
        end
    end

    generate
        for (genvar e = 0; e < N_EVT; e++) begin : g_evt
            logic rise;
            logic chg;
            // Classify the change seen on this event
            always_comb begin
                rise = live_i[e] & ~prev_q[e];
                chg  = live_i[e] ^ prev_q[e];
            end
            // Select the change that counts for this event's mode
            always_comb begin
                hit_o[e] = any_mode_i[e] ? chg : rise;
            end
        end
    endgenerate

endmodule

// File: rtl/evt_sticky_bank.sv
// Sticky flag bank: a set request latches a flag, and a write of 1 clears
// it. A set and a clear on the same edge leave the flag set. Bits outside
// KEEP_MASK are reserved: they are held at 0 and ignore writes.
module evt_sticky_bank #(
    parameter int unsigned           W         = 8,
    parameter logic [W-1:0]          KEEP_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_q;
    logic [W-1:0] clr;
    logic [W-1:0] flags_d;

    // Decode the clear request from the write port
    always_comb begin
        clr = wr_en_i ? wr_data_i : '0;
    end

    // Set has priority over clear; reserved bits forced to zero
    always_comb begin
        flags_d = ((flags_q & ~clr) | set_i) & KEEP_MASK;
    end

    // Hold the flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb flags_o = flags_q;

endmodule

// File: rtl/evt_irq_reg.sv
// Interrupt register: ORs all status flags and registers the result.
// Assumes the reserved flags arrive as zero.
module evt_irq_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    output logic         irq_o
);

    logic irq_q;

    // Register the OR of all flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |flags_i;
        end
    end

    always_comb irq_o = irq_q;

endmodule

// File: rtl/evt_sticky_status.sv
// Top: per-channel sticky event status register with edge-selectable
// capture. It gathers five live levels and expands the three group edge
// controls to the five events. Qualified edges are mapped to fixed bit
// positions, then latched, read back and reduced to an interrupt.
// Assumes the live levels and controls are synchronous to clk.
module evt_sticky_status
    import evt_status_pkg::*;
#(
    parameter int unsigned REG_W = STAT_W,
    parameter int unsigned N_EVT = EVT_NUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_alarm_i,
    input  logic             line_alarm_i,
    input  logic             pat_sync_i,
    input  logic             act_code_i,
    input  logic             deact_code_i,
    input  logic             alarm_anyedge_i,
    input  logic             sync_anyedge_i,
    input  logic             code_anyedge_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o
);

    logic [N_EVT-1:0]   live;
    logic [GRP_NUM-1:0] grp_mode;
    logic [N_EVT-1:0]   evt_mode;
    logic [N_EVT-1:0]   evt_hit;
    logic [REG_W-1:0]   set_map;
    logic [REG_W-1:0]   flags;

    // Gather the live levels in event-index order
    always_comb begin
        live[EVT_SYS_ALARM]  = sys_alarm_i;
        live[EVT_LINE_ALARM] = line_alarm_i;
        live[EVT_PAT_SYNC]   = pat_sync_i;
        live[EVT_ACT_CODE]   = act_code_i;
        live[EVT_DEACT_CODE] = deact_code_i;
    end

    // Gather the group edge controls
    always_comb begin
        grp_mode[GRP_ALARM] = alarm_anyedge_i;
        grp_mode[GRP_SYNC]  = sync_anyedge_i;
        grp_mode[GRP_CODE]  = code_anyedge_i;
    end

    // Expand group controls to events, and map hits onto status bits
    generate
        for (genvar e = 0; e < N_EVT; e++) begin : g_map
            localparam int unsigned GRP = evt_group(e);
            always_comb evt_mode[e] = grp_mode[GRP];
        end
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            logic hit_here;
            // Find the event, if any, that owns this status bit
            always_comb begin
                hit_here = 1'b0;
                for (int e = 0; e < N_EVT; e++) begin
                    if (evt_bit_pos(e) == b) begin
                        hit_here = evt_hit[e];
                    end
                end
            end
            always_comb set_map[b] = hit_here;
        end
    endgenerate

    evt_edge_qual #(
        .N_EVT      (N_EVT)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_i     (live),
        .any_mode_i (evt_mode),
        .hit_o      (evt_hit)
    );

    evt_sticky_bank #(
        .W          (REG_W),
        .KEEP_MASK  (IMPL_MASK)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_map),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .flags_o    (flags)
    );

    evt_irq_reg #(
        .W          (REG_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flags),
        .irq_o      (irq_o)
    );

    always_comb rd_data_o = flags;

endmodule

// File: rtl/evt_sticky_status_chk.sv
// Checker for evt_sticky_status, bound to every instance of it. Assumes
// the live levels are low during reset and change only between edges.
module evt_sticky_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_alarm_i,
    input logic       line_alarm_i,
    input logic       pat_sync_i,
    input logic       act_code_i,
    input logic       deact_code_i,
    input logic       alarm_anyedge_i,
    input logic       sync_anyedge_i,
    input logic       code_anyedge_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       irq_o
);

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_alarm_i) |=> rd_data_o[7]);

    assert_fall_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_anyedge_i && $fell(act_code_i) && !rd_data_o[1] && !deact_code_i)
        |=> !rd_data_o[1]);

    assert_anyedge_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_anyedge_i && $fell(line_alarm_i)) |=> rd_data_o[6]);

    assert_sync_anyedge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_anyedge_i && $fell(pat_sync_i)) |=> rd_data_o[5]);

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[5] && $stable(pat_sync_i)) |=> !rd_data_o[5]);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[0] && $rose(deact_code_i)) |=> rd_data_o[0]);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[4:2] == 3'b000);

    assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o != 8'h00) |=> irq_o);

    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o == 8'h00) |=> !irq_o);

    assert_flag_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[1] && !(wr_en_i && wr_data_i[1])) |=> rd_data_o[1]);

endmodule

bind evt_sticky_status evt_sticky_status_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sys_alarm_i     (sys_alarm_i),
    .line_alarm_i    (line_alarm_i),
    .pat_sync_i      (pat_sync_i),
    .act_code_i      (act_code_i),
    .deact_code_i    (deact_code_i),
    .alarm_anyedge_i (alarm_anyedge_i),
    .sync_anyedge_i  (sync_anyedge_i),
    .code_anyedge_i  (code_anyedge_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .rd_data_o       (rd_data_o),
    .irq_o           (irq_o)
);

// File: tb/evt_sticky_status_tb_top.sv
// Directed bench for evt_sticky_status: one task per scenario.
module evt_sticky_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] lv;          // {sys, line, sync, act, deact}
    logic       alarm_any, sync_any, code_any;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_sticky_status dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .sys_alarm_i     (lv[4]),
        .line_alarm_i    (lv[3]),
        .pat_sync_i      (lv[2]),
        .act_code_i      (lv[1]),
        .deact_code_i    (lv[0]),
        .alarm_anyedge_i (alarm_any),
        .sync_anyedge_i  (sync_any),
        .code_anyedge_i  (code_any),
        .wr_en_i         (wr_en),
        .wr_data_i       (wr_data),
        .rd_data_o       (rd_data),
        .irq_o           (irq)
    );

    // Status bit for each entry of lv
    function automatic int bitpos(input int i);
        case (i)
            4: return 7;
            3: return 6;
            2: return 5;
            1: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_reset();
        lv = '0; wr_en = 1'b0; wr_data = 8'h00;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step();
    endtask

    // R1: reset state, also after flags had been set
    task automatic t_reset();
        alarm_any = 0; sync_any = 0; code_any = 0;
        do_reset();
        chk8("R1 status after reset", rd_data, 8'h00);
        chk1("R1 irq after reset", irq, 1'b0);
        lv = 5'b11111; step(2);
        lv = '0;
        do_reset();
        chk8("R1 status after second reset", rd_data, 8'h00);
        chk1("R1 irq after second reset", irq, 1'b0);
    endtask

    // R2, R3, R7, R10, R11: each event with rising-only capture
    task automatic t_rising_each();
        alarm_any = 0; sync_any = 0; code_any = 0;
        for (int i = 0; i < 5; i++) begin
            logic [7:0] e;
            e = 8'h01 << bitpos(i);
            lv[i] = 1'b1; step();
            chk8("R2 rising edge sets flag", rd_data, e);
            chk1("R10 irq lags status", irq, 1'b0);
            step();
            chk1("R10 irq rises", irq, 1'b1);
            lv[i] = 1'b0; step();
            chk8("R3/R11 falling edge ignored, flag kept", rd_data, e);
            do_write(~e);
            chk8("R7 write 0 leaves flag", rd_data, e);
            do_write(e);
            chk8("R7 write 1 clears flag", rd_data, 8'h00);
            chk1("R10 irq still high one cycle", irq, 1'b1);
            step();
            chk1("R10 irq falls", irq, 1'b0);
        end
    endtask

    // R4, R5, R6: group sharing of the edge controls
    task automatic t_groups();
        for (int g = 0; g < 3; g++) begin
            logic [7:0] exp_fall;
            alarm_any = (g == 0); sync_any = (g == 1); code_any = (g == 2);
            exp_fall = (g == 0) ? 8'hC0 : (g == 1) ? 8'h20 : 8'h03;
            lv = 5'b11111; step();
            chk8("R2 all rising", rd_data, 8'hE3);
            do_write(8'hFF);
            chk8("R7 clear all", rd_data, 8'h00);
            lv = 5'b00000; step();
            if (g == 0) chk8("R4/R5 alarm group any-edge", rd_data, exp_fall);
            if (g == 1) chk8("R4/R6 sync own any-edge", rd_data, exp_fall);
            if (g == 2) chk8("R4/R6 code group any-edge", rd_data, exp_fall);
            do_write(8'hFF);
        end
        alarm_any = 0; sync_any = 0; code_any = 0;
        step();
    endtask

    // R8: set beats clear on the same edge
    task automatic t_set_wins();
        lv[1] = 1'b1; step();
        chk8("R8 setup", rd_data, 8'h02);
        lv[1] = 1'b0; step();
        lv[1] = 1'b1; wr_en = 1'b1; wr_data = 8'h02;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
        chk8("R8 set wins over clear", rd_data, 8'h02);
        lv[0] = 1'b1; wr_en = 1'b1; wr_data = 8'h03;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
        chk8("R8 clear other bit, set this one", rd_data, 8'h01);
        lv = '0; do_write(8'hFF);
    endtask

    // R9: reserved bits read zero and ignore writes
    task automatic t_reserved();
        lv = 5'b11111; step();
        chk8("R9 reserved read 0", rd_data & 8'h1C, 8'h00);
        do_write(8'h1C);
        chk8("R9 reserved write no effect", rd_data, 8'hE3);
        lv = '0; do_write(8'hFF);
        chk8("R9 cleared", rd_data, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; lv = '0; wr_en = 1'b0; wr_data = 8'h00;
        alarm_any = 0; sync_any = 0; code_any = 0;
        t_reset();
        t_rising_each();
        t_groups();
        t_set_wins();
        t_reserved();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule